// File: doc/BRIEF.md
# Ternary Modular Inverse Unit

This unit takes a K-digit radix-3 operand, with every digit packed into two bits, and returns its multiplicative inverse modulo 3^K in the same packed form. A caller raises a one-cycle start pulse with the operand and an output-format select. Some cycles later a one-cycle done pulse marks a new result and an error flag. The result and the flag stay on the outputs until the next completion.

Only operands that 3 does not divide have an inverse. These are the operands whose lowest digit is nonzero, two thirds of all K-digit values. The unit rejects an operand whose lowest digit is zero, or any operand that contains the unused digit code. The work is done in binary. The operand is converted from radix 3 to a binary value. A Newton iteration doubles the number of correct low digits on every pass. The binary result is then split back into radix-3 digits. Because of this digit growth, the low n digits of the inverse depend only on the low n digits of the operand.

The result can also be re-labelled into one of two balanced-ternary digit codings. The format is chosen when the operation is accepted.

Top module: `tern_inv_unit`

## Requirements
- R1: Digit i of an operand or result occupies bits [2i+1:2i], and the least significant digit sits at bits [1:0]. The digit codes are 00=0, 01=1 and 10=2. For a legal operand a whose lowest digit is nonzero, with format select 00 or 11, the unit returns digits r, each coded 00, 01 or 10, such that a*r mod 3^K = 1, and err_o is 0.
- R2: An operand whose lowest digit is coded 00 gives err_o=1 and a result of all zeros.
- R3: An operand with any digit coded 11 gives err_o=1 and a result of all zeros.
- R4: With format select 01, each standard result digit is re-coded as 0→00, 1→01 and 2→11.
- R5: With format select 10, each standard result digit is re-coded as 0→11, 1→00 and 2→01.
- R6: done_o is a single-cycle pulse. Let NITER be ceil(log2 K), with a minimum of 1. For a legal operand, done_o is high in the cycle that begins NITER+1 clock edges after the edge that samples start_i. For a rejected operand, it is high in the cycle that begins 1 edge after that edge.
- R7: While an operation is in progress, start_i is ignored. The result belongs to the first operand, and no extra done_o pulse appears.
- R8: result_o and err_o change only at a completion. Between completions they hold their values, whatever happens on digits_i and mode_i. The format select is sampled together with start_i.
- R9: The low n digits of the standard result equal the inverse modulo 3^n of the low n digits of the operand, for every n from 1 to K.
- R10: After reset, done_o, err_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| digits_i | input | 2*K | Packed radix-3 operand |
| mode_i | input | 2 | Output format: 00 or 11 standard, 01 balanced map A, 10 balanced map B |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operand had no inverse or held an illegal digit |
| result_o | output | 2*K | Packed result digits |

## Verification
The assertions take the handshake for granted. start_i is judged only in the idle state. The Newton core is assumed to start from a seed whose lowest digit already inverts the operand's lowest digit, so the core's invariant holds from the first step it takes. The bench raises start only while the unit is idle, apart from one deliberate overlap that exercises R7. Every operand it drives is an exact K-digit pattern. Illegal codes appear only in the tests for R3.

// File: rtl/tinv_pkg.sv
package tinv_pkg;

  typedef enum logic [1:0] {
    FMT_STD   = 2'b00,
    FMT_BAL_A = 2'b01,
    FMT_BAL_B = 2'b10,
    FMT_STD_X = 2'b11
  } out_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } seq_st_e;

  // re-label one standard digit code for the selected output format
  function automatic logic [1:0] map_digit(input logic [1:0] d, input out_fmt_e f);
    logic [1:0] r;
    r = d;
    unique case (f)
      FMT_BAL_A: r = (d == 2'b10) ? 2'b11 : d;
      FMT_BAL_B: r = (d == 2'b00) ? 2'b11 : (d == 2'b01) ? 2'b00 : 2'b01;
      default:   r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tinv_unpack.sv
module tinv_unpack #(
  parameter int unsigned K = 4,
  parameter int unsigned W = 8
) (
  input  logic [2*K-1:0] digits_i,
  output logic [W-1:0]   value_o,
  output logic           bad_o
);
  logic [W-1:0] acc [K+1];
  logic [K-1:0] illegal;

  assign acc[0] = '0;

  for (genvar i = 0; i < K; i++) begin : g_dig
    localparam logic [W-1:0] WEIGHT = W'(3 ** i);
    logic [1:0] code;
    assign code       = digits_i[2*i +: 2];
    assign illegal[i] = (code == 2'b11);
    assign acc[i+1]   = acc[i] + W'(code) * WEIGHT;
  end

  assign value_o = acc[K];
  assign bad_o   = (|illegal) || (digits_i[1:0] == 2'b00);

endmodule

// File: rtl/tinv_newton.sv
module tinv_newton #(
  parameter int unsigned K     = 4,
  parameter int unsigned W     = 8,
  parameter int unsigned NITER = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         run_i,
  input  logic [W-1:0] operand_i,
  output logic         last_o,
  output logic [W-1:0] inv_o
);
  localparam int unsigned MOD = 3 ** K;
  localparam int unsigned CW  = (NITER > 1) ? $clog2(NITER) : 1;
  localparam logic [2*W-1:0] MOD2 = (2*W)'(MOD);

  logic [W-1:0]   a_q, y_q, y_seed, t, u, y_nxt;
  logic [2*W-1:0] p_ay, p_yu;
  logic [CW-1:0]  cnt_q;

  // seed is correct modulo 3: 1*1 = 1, 2*2 = 4
  assign y_seed = (operand_i % W'(3) == W'(1)) ? W'(1) : W'(2);

  // y <- y * (2 - a*y) mod 3^K
  assign p_ay  = (2*W)'(a_q) * (2*W)'(y_q);
  assign t     = W'(p_ay % MOD2);
  assign u     = (t <= W'(2)) ? (W'(2) - t) : (W'(MOD) + W'(2) - t);
  assign p_yu  = (2*W)'(y_q) * (2*W)'(u);
  assign y_nxt = W'(p_yu % MOD2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      y_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      a_q   <= operand_i;
      y_q   <= y_seed;
      cnt_q <= '0;
    end else if (run_i) begin
      y_q   <= y_nxt;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign last_o = run_i && (cnt_q == CW'(NITER - 1));
  assign inv_o  = y_q;

  // lowest digit stays inverted through every step (R9)
  p_low_digit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ((a_q % W'(3) == W'(1)) ? (y_q % W'(3) == W'(1)) : (y_q % W'(3) == W'(2))));

  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (y_q < W'(MOD)));

endmodule

// File: rtl/tinv_pack.sv
module tinv_pack #(
  parameter int unsigned K = 4,
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]      value_i,
  input  tinv_pkg::out_fmt_e fmt_i,
  output logic [2*K-1:0]    digits_o
);
  logic [W-1:0] q [K];

  assign q[0] = value_i;

  for (genvar i = 0; i < K; i++) begin : g_dig
    logic [1:0] d;
    assign d = 2'(q[i] % W'(3));
    assign digits_o[2*i +: 2] = tinv_pkg::map_digit(d, fmt_i);
    if (i < K - 1) begin : g_next
      assign q[i+1] = q[i] / W'(3);
    end
  end

endmodule

// File: rtl/tern_inv_unit.sv
module tern_inv_unit #(
  parameter int unsigned K = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*K-1:0] digits_i,
  input  logic [1:0]     mode_i,
  output logic           done_o,
  output logic           err_o,
  output logic [2*K-1:0] result_o
);
  import tinv_pkg::*;

  localparam int unsigned MOD   = 3 ** K;
  localparam int unsigned W     = $clog2(MOD) + 1;
  localparam int unsigned NITER = (K > 1) ? $clog2(K) : 1;

  seq_st_e        st_q;
  out_fmt_e       fmt_q;
  logic           bad_q, load, run, last;
  logic [W-1:0]   op_bin, inv_bin;
  logic           op_bad;
  logic [2*K-1:0] packed_res;
  logic           done_q, err_q;
  logic [2*K-1:0] res_q;

  tinv_unpack #(.K(K), .W(W)) u_unpack (
    .digits_i (digits_i),
    .value_o  (op_bin),
    .bad_o    (op_bad)
  );

  assign load = (st_q == ST_IDLE) && start_i && !op_bad;
  assign run  = (st_q == ST_RUN);

  tinv_newton #(.K(K), .W(W), .NITER(NITER)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .run_i     (run),
    .operand_i (op_bin),
    .last_o    (last),
    .inv_o     (inv_bin)
  );

  tinv_pack #(.K(K), .W(W)) u_pack (
    .value_i  (inv_bin),
    .fmt_i    (fmt_q),
    .digits_o (packed_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fmt_q  <= FMT_STD;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          fmt_q <= out_fmt_e'(mode_i);
          bad_q <= op_bad;
          st_q  <= op_bad ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (last) st_q <= ST_FIN;
        ST_FIN: begin
          done_q <= 1'b1;
          err_q  <= bad_q;
          res_q  <= bad_q ? '0 : packed_res;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = res_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (result_o == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(err_o)));

  p_busy_fmt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |=> $stable(fmt_q));

  p_legal_codes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (fmt_q == FMT_STD || fmt_q == FMT_STD_X))
      |-> !(|(result_o & {K{2'b10}} & (result_o << 1))));

endmodule

// File: tb/tern_inv_unit_tb.sv
module tern_inv_unit_tb;
  localparam int K     = 4;
  localparam int MOD   = 81;
  localparam int NITER = 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [2*K-1:0] digits_i = '0;
  logic [1:0]     mode_i = 2'b00;
  logic           done_o, err_o;
  logic [2*K-1:0] result_o;

  int total = 0;
  int bad = 0;
  bit timed_out = 0;

  tern_inv_unit #(.K(K)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .digits_i(digits_i),
    .mode_i(mode_i), .done_o(done_o), .err_o(err_o), .result_o(result_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [2*K-1:0] enc(input int v);
    logic [2*K-1:0] r;
    int x;
    x = v;
    for (int i = 0; i < K; i++) begin
      r[2*i +: 2] = 2'(x % 3);
      x = x / 3;
    end
    return r;
  endfunction

  function automatic int ref_inv(input int a, input int m);
    for (int y = 0; y < m; y++) if ((a * y) % m == 1) return y;
    return -1;
  endfunction

  function automatic logic [2*K-1:0] remap(input logic [2*K-1:0] s, input logic [1:0] f);
    logic [2*K-1:0] r;
    for (int i = 0; i < K; i++) begin
      logic [1:0] d;
      d = s[2*i +: 2];
      case (f)
        2'b01:   r[2*i +: 2] = (d == 2'd0) ? 2'b00 : (d == 2'd1) ? 2'b01 : 2'b11;
        2'b10:   r[2*i +: 2] = (d == 2'd0) ? 2'b11 : (d == 2'd1) ? 2'b00 : 2'b01;
        default: r[2*i +: 2] = d;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one operation and return the number of edges until done is seen
  task automatic run_op(input logic [2*K-1:0] d, input logic [1:0] m, output int lat);
    @(negedge clk_i);
    digits_i = d; mode_i = m; start_i = 1'b1;
    lat = 0;
    @(posedge clk_i);
    lat = 1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && lat < 50) begin
      @(posedge clk_i); lat++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    check("R10 done", 32'(done_o), 0);
    check("R10 err", 32'(err_o), 0);
    check("R10 result", 32'(result_o), 0);
  endtask

  task automatic t_exhaustive;
    int lat;
    for (int a = 0; a < MOD; a++) begin
      run_op(enc(a), 2'b00, lat);
      if (a % 3 != 0) begin
        int r;
        r = 0;
        for (int i = K - 1; i >= 0; i--) r = r * 3 + int'(result_o[2*i +: 2]);
        check("R1 product", 32'((a * r) % MOD), 1);
        check("R1 err", 32'(err_o), 0);
        check("R6 latency", 32'(lat), 32'(NITER + 2));
        for (int n = 1; n <= K; n++) begin
          int m;
          m = 3 ** n;
          check("R9 low digits", 32'(r % m), 32'(ref_inv(a % m, m)));
        end
      end else begin
        check("R2 err", 32'(err_o), 1);
        check("R2 zero", 32'(result_o), 0);
        check("R6 error latency", 32'(lat), 2);
      end
    end
  endtask

  task automatic t_pairs;
    int pa [14] = '{2, 4, 8, 16, 32, 64, 47, 13, 26, 52, 23, 46, 11, 1};
    int pb [14] = '{41, 61, 71, 76, 38, 19, 50, 25, 53, 67, 74, 37, 59, 1};
    int lat;
    for (int i = 0; i < 14; i++) begin
      run_op(enc(pa[i]), 2'b11, lat);
      check("R1 pair fwd", 32'(result_o), 32'(enc(pb[i])));
      run_op(enc(pb[i]), 2'b00, lat);
      check("R1 pair back", 32'(result_o), 32'(enc(pa[i])));
    end
  endtask

  task automatic t_illegal;
    int lat;
    run_op(8'b11_00_00_01, 2'b00, lat);
    check("R3 err top", 32'(err_o), 1);
    check("R3 zero", 32'(result_o), 0);
    check("R6 err latency", 32'(lat), 2);
    run_op(8'b00_00_00_11, 2'b01, lat);
    check("R3 err lsd", 32'(err_o), 1);
    check("R3 zero lsd", 32'(result_o), 0);
  endtask

  task automatic t_modes;
    int lat;
    int vals [4] = '{2, 5, 47, 80};
    foreach (vals[i]) begin
      logic [2*K-1:0] s;
      s = enc(ref_inv(vals[i], MOD));
      run_op(enc(vals[i]), 2'b01, lat);
      check("R4 map A", 32'(result_o), 32'(remap(s, 2'b01)));
      run_op(enc(vals[i]), 2'b10, lat);
      check("R5 map B", 32'(result_o), 32'(remap(s, 2'b10)));
    end
  endtask

  task automatic t_busy;
    int dones;
    @(negedge clk_i);
    digits_i = enc(2); mode_i = 2'b00; start_i = 1'b1;
    @(negedge clk_i);
    digits_i = enc(4); mode_i = 2'b10;
    @(negedge clk_i);
    start_i = 1'b0;
    dones = 0;
    for (int c = 0; c < 10; c++) begin
      if (done_o) begin
        dones++;
        check("R7 first operand kept", 32'(result_o), 32'(enc(41)));
      end
      @(negedge clk_i);
    end
    check("R7 single done", 32'(dones), 1);
  endtask

  task automatic t_hold;
    int lat;
    run_op(enc(13), 2'b00, lat);
    @(negedge clk_i);
    digits_i = enc(3); mode_i = 2'b01;
    repeat (6) @(negedge clk_i);
    check("R8 result held", 32'(result_o), 32'(enc(25)));
    check("R8 err held", 32'(err_o), 0);
    check("R8 no done", 32'(done_o), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_exhaustive();
        t_pairs();
        t_illegal();
        t_modes();
        t_busy();
        t_hold();
      end
      begin
        repeat (100000) @(posedge clk_i);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule